// File: doc/BRIEF.md
# Mains-rate tick clock with control register

This block produces a periodic tick at either 50 or 60 ticks per second, derived from the system clock by a counter whose limit is computed from the system clock frequency. Each tick is recorded in a DONE flag and, when enabled, raises a level interrupt request toward the processor. Software sees a single 16-bit control/status word that holds the interrupt enable bit and, in some variants, the DONE flag.

Four strap inputs pick the register variant the surrounding system expects. The register may be missing, so that every access returns a bus error. DONE may be hidden from reads. DONE may be cleared by software writing a zero into it. DONE may be cleared when the processor acknowledges the interrupt. When the register is missing, a separate strap can force tick interrupts on without any enable bit. The tick rate is set through a rate-load strobe, and reset returns it to a parameter default.

Top module: `line_tick_clock`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, DONE reads as 1 and IE as 0. `irq` is 0. The rate is the default (`DEFAULT_50HZ`), and the tick counter starts from zero.
- R2: The tick period is `SYS_CLK_HZ/60` cycles at 60 Hz and `SYS_CLK_HZ/50` cycles at 50 Hz. A tick takes effect `P+1` cycles after reset release or a rate load, then every `P` cycles after that. A pulse on `rate_ld` sets 50 Hz when `rate_ld_50` is 1 and 60 Hz when it is 0, and restarts the counter from zero.
- R3: A tick sets DONE. It also sets `irq` if IE is 1 or forced enable is active.
- R4: A write with `bus_odd` at 0 loads IE from bit 6 of `bus_wdata`. No other bit loads state, apart from R5. A write with `bus_odd` at 1 changes nothing, including `irq`.
- R5: With `strap_mon` at 1, an even write whose bit 7 is 0 clears DONE, and one whose bit 7 is 1 leaves DONE unchanged. With `strap_mon` at 0, writes never change DONE.
- R6: A read drives `bus_rdata` in the following cycle. Bit 6 holds IE. Bit 7 holds DONE only when `strap_mon` is 1, and is 0 otherwise. All other bits are 0. Cycles without a read show 0.
- R7: After an even write, `irq` drops if DONE is now 0, or if IE is now 0 and forced enable is off. A write never sets `irq`.
- R8: `irq` is a registered level that only ticks set. A pulse on `iak` always drops it.
- R9: With `strap_iak_clr` at 1, `iak` also clears DONE.
- R10: With `strap_absent` at 1, every read or write gives `bus_nxm` high for exactly the following cycle. `bus_rdata` stays 0 and IE and DONE do not change. Forced enable equals `strap_force`. With `strap_absent` at 0, forced enable is off and `bus_nxm` stays 0.
- R11: Events in the same cycle apply in this order: write, then acknowledge, then tick. A tick therefore leaves DONE at 1 even when a write or acknowledge in that cycle would clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_absent | input | 1 | Register missing: accesses give a bus error |
| strap_force | input | 1 | Forced interrupt enable when the register is missing |
| strap_mon | input | 1 | DONE visible on read and clearable by writing 0 |
| strap_iak_clr | input | 1 | Interrupt acknowledge clears DONE |
| rate_ld | input | 1 | Load tick rate and restart the counter |
| rate_ld_50 | input | 1 | Rate to load: 1 = 50 Hz, 0 = 60 Hz |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_odd | input | 1 | Access targets the odd (upper) byte |
| bus_wdata | input | 16 | Write data |
| iak | input | 1 | Interrupt acknowledge pulse |
| bus_rdata | output | 16 | Read data, one cycle after `bus_rd` |
| bus_nxm | output | 1 | Bus error, one cycle after an access to a missing register |
| irq | output | 1 | Interrupt request level |

## Verification
If the tick counter drifts, the DONE bit and `irq` rise in the wrong cycle, so the error shows within one tick period. A DONE or IE flag with a wrong value shows at the next read, or at the next tick as a wrong `irq` edge. Getting the same-cycle order wrong shows only when a write or acknowledge lands on a tick cycle. The bench therefore compares `bus_rdata`, `bus_nxm` and `irq` against a reference model on every clock, while writes and acknowledges arrive on pseudo-random cycles across every strap combination.

// File: rtl/line_tick_pkg.sv
package line_tick_pkg;
  localparam int CSR_W    = 16;
  localparam int IE_POS   = 6;
  localparam int DONE_POS = 7;

  typedef struct packed {
    logic absent;
    logic force_opt;
    logic mon;
    logic iak_clr;
  } tick_cfg_t;
endpackage

// File: rtl/tick_rate_div.sv
module tick_rate_div #(
  parameter int SYS_CLK_HZ   = 6000,
  parameter bit DEFAULT_50HZ = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic rate_ld,
  input  logic rate_ld_50,
  output logic tick
);
  localparam int P50   = SYS_CLK_HZ / 50;
  localparam int P60   = SYS_CLK_HZ / 60;
  localparam int PMAX  = (P50 > P60) ? P50 : P60;
  localparam int CNT_W = $clog2(PMAX + 1);

  logic             sel50_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last = sel50_q ? CNT_W'(P50 - 1) : CNT_W'(P60 - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel50_q <= DEFAULT_50HZ;
      cnt_q   <= '0;
      tick    <= 1'b0;
    end else if (rate_ld) begin
      sel50_q <= rate_ld_50;
      cnt_q   <= '0;
      tick    <= 1'b0;
    end else if (cnt_q == last) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end

  // R2: counter never passes the selected period
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last);
  // R2: a tick is followed by a counter wrap to zero unless restarted
  a_r2_tick_wrap: assert property (@(posedge clk) disable iff (rst)
    tick |-> (cnt_q == '0));
endmodule

// File: rtl/tick_csr.sv
module tick_csr
  import line_tick_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  tick_cfg_t        cfg,
  input  logic             tick,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic             bus_odd,
  input  logic [CSR_W-1:0] bus_wdata,
  input  logic             iak,
  output logic [CSR_W-1:0] bus_rdata,
  output logic             bus_nxm,
  output logic             irq
);
  logic done_q, ie_q;
  logic done_n, ie_n, irq_n;
  logic force_en, wr_hit;
  logic unused_wbits;

  assign unused_wbits = ^{bus_wdata[CSR_W-1:DONE_POS+1], bus_wdata[IE_POS-1:0]};
  assign force_en = cfg.absent & cfg.force_opt;
  assign wr_hit   = bus_wr & ~cfg.absent & ~bus_odd;

  always_comb begin
    done_n = done_q;
    ie_n   = ie_q;
    irq_n  = irq;
    if (wr_hit) begin
      ie_n = bus_wdata[IE_POS];
      if (cfg.mon && !bus_wdata[DONE_POS]) done_n = 1'b0;
      if (!done_n || (!ie_n && !force_en)) irq_n = 1'b0;
    end
    if (iak) begin
      irq_n = 1'b0;
      if (cfg.iak_clr) done_n = 1'b0;
    end
    if (tick) begin
      done_n = 1'b1;
      if (ie_n || force_en) irq_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q    <= 1'b1;
      ie_q      <= 1'b0;
      irq       <= 1'b0;
      bus_rdata <= '0;
      bus_nxm   <= 1'b0;
    end else begin
      done_q    <= done_n;
      ie_q      <= ie_n;
      irq       <= irq_n;
      bus_nxm   <= cfg.absent & (bus_rd | bus_wr);
      bus_rdata <= '0;
      if (bus_rd && !cfg.absent) begin
        bus_rdata[IE_POS]   <= ie_q;
        bus_rdata[DONE_POS] <= done_q & cfg.mon;
      end
    end
  end

  // R3: every tick leaves DONE set
  a_r3_tick_sets_done: assert property (@(posedge clk) disable iff (rst)
    tick |=> done_q);
  // R8: a pending request always has DONE behind it
  a_r8_irq_needs_done: assert property (@(posedge clk) disable iff (rst)
    irq |-> done_q);
  // R8: acknowledge without a tick drops the request
  a_r8_iak_drops: assert property (@(posedge clk) disable iff (rst)
    (iak && !tick) |=> !irq);
  // R4: odd-byte write alone touches nothing
  a_r4_odd_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_odd && !tick && !iak) |=> ($stable(ie_q) && $stable(done_q) && $stable(irq)));
  // R10: missing register answers with a bus error
  a_r10_nxm: assert property (@(posedge clk) disable iff (rst)
    (cfg.absent && (bus_rd || bus_wr)) |=> bus_nxm);
  // R7: a write never raises the request
  a_r7_write_no_raise: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !tick && !irq) |=> !irq);
endmodule

// File: rtl/line_tick_clock.sv
module line_tick_clock
  import line_tick_pkg::*;
#(
  parameter int SYS_CLK_HZ   = 6000,
  parameter bit DEFAULT_50HZ = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strap_absent,
  input  logic             strap_force,
  input  logic             strap_mon,
  input  logic             strap_iak_clr,
  input  logic             rate_ld,
  input  logic             rate_ld_50,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic             bus_odd,
  input  logic [CSR_W-1:0] bus_wdata,
  input  logic             iak,
  output logic [CSR_W-1:0] bus_rdata,
  output logic             bus_nxm,
  output logic             irq
);
  tick_cfg_t cfg;
  logic      tick;

  assign cfg = '{absent: strap_absent, force_opt: strap_force,
                 mon: strap_mon, iak_clr: strap_iak_clr};

  tick_rate_div #(.SYS_CLK_HZ(SYS_CLK_HZ), .DEFAULT_50HZ(DEFAULT_50HZ)) u_div (
    .clk(clk), .rst(rst), .rate_ld(rate_ld), .rate_ld_50(rate_ld_50), .tick(tick)
  );

  tick_csr u_csr (
    .clk(clk), .rst(rst), .cfg(cfg), .tick(tick),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_odd(bus_odd), .bus_wdata(bus_wdata),
    .iak(iak), .bus_rdata(bus_rdata), .bus_nxm(bus_nxm), .irq(irq)
  );

  // R10: no bus error when the register is present
  a_r10_no_nxm_present: assert property (@(posedge clk) disable iff (rst)
    !strap_absent |=> (!bus_nxm || $past(strap_absent)));
  // R6: read data is quiet without a read
  a_r6_quiet_rdata: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

// File: tb/tb_line_tick_clock.sv
module tb_line_tick_clock;
  localparam int CLK_PERIOD = 10;
  localparam int SYS_HZ     = 6000;
  localparam bit DEF50      = 1'b0;

  logic clk = 0, rst = 1;
  logic s_abs = 0, s_frc = 0, s_mon = 0, s_iak = 0;
  logic rate_ld = 0, rate_ld_50 = 0;
  logic bus_rd = 0, bus_wr = 0, bus_odd = 0, iak = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic bus_nxm, irq;

  int checks = 0, bad = 0, cycles = 0;
  bit  done_flag = 0;
  string cur_req = "R1";

  line_tick_clock #(.SYS_CLK_HZ(SYS_HZ), .DEFAULT_50HZ(DEF50)) dut (
    .clk(clk), .rst(rst), .strap_absent(s_abs), .strap_force(s_frc),
    .strap_mon(s_mon), .strap_iak_clr(s_iak), .rate_ld(rate_ld),
    .rate_ld_50(rate_ld_50), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_odd(bus_odd),
    .bus_wdata(bus_wdata), .iak(iak), .bus_rdata(bus_rdata), .bus_nxm(bus_nxm),
    .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  bit m_done = 1, m_ie = 0, m_irq = 0, m_r50 = DEF50, m_nxm = 0;
  logic [15:0] m_rdata = 0;
  int m_age = 0;
  int per;
  bit eff, frc;

  always @(posedge clk) begin
    if (rst) begin
      m_done = 1; m_ie = 0; m_irq = 0; m_r50 = DEF50; m_age = 0;
      m_rdata = 0; m_nxm = 0;
    end else begin
      per = m_r50 ? SYS_HZ / 50 : SYS_HZ / 60;
      eff = (m_age > 0) && (m_age % per == 0);
      frc = s_abs & s_frc;
      m_nxm = s_abs && (bus_rd || bus_wr);
      m_rdata = 0;
      if (bus_rd && !s_abs) begin
        m_rdata[6] = m_ie;
        m_rdata[7] = m_done & s_mon;
      end
      if (bus_wr && !s_abs && !bus_odd) begin
        m_ie = bus_wdata[6];
        if (s_mon && !bus_wdata[7]) m_done = 0;
        if (!m_done || (!m_ie && !frc)) m_irq = 0;
      end
      if (iak) begin
        m_irq = 0;
        if (s_iak) m_done = 0;
      end
      if (eff) begin
        m_done = 1;
        if (m_ie || frc) m_irq = 1;
      end
      if (rate_ld) begin m_r50 = rate_ld_50; m_age = 0; end
      else m_age++;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!done_flag) begin
      checks++;
      if (bus_rdata !== m_rdata || bus_nxm !== m_nxm || irq !== m_irq) begin
        bad++;
        $display("FAIL %s cycle %0d: got rdata=%h nxm=%b irq=%b expected rdata=%h nxm=%b irq=%b",
                 cur_req, cycles, bus_rdata, bus_nxm, irq, m_rdata, m_nxm, m_irq);
      end
    end
    if (cycles > 150000 && !done_flag) begin
      bad++; checks++;
      $display("FAIL watchdog: got cycles=%0d expected < 150000", cycles);
      finish_run();
    end
  end

  task automatic finish_run();
    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset(bit a, bit f, bit m, bit k);
    @(negedge clk);
    rst = 1; s_abs = a; s_frc = f; s_mon = m; s_iak = k;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [15:0] d, bit odd);
    @(negedge clk);
    bus_wr = 1; bus_wdata = d; bus_odd = odd;
    @(negedge clk);
    bus_wr = 0; bus_odd = 0;
  endtask

  task automatic rd(output logic [15:0] v);
    @(negedge clk);
    bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    v = bus_rdata;
  endtask

  task automatic ack();
    @(negedge clk); iak = 1;
    @(negedge clk); iak = 0;
  endtask

  task automatic load_rate(bit r50);
    @(negedge clk); rate_ld = 1; rate_ld_50 = r50;
    @(negedge clk); rate_ld = 0;
  endtask

  initial begin
    logic [15:0] v;
    // R1 reset state, monitor variant so DONE is visible
    cur_req = "R1";
    do_reset(0, 0, 1, 0);
    chk("R1 irq after reset", {15'd0, irq}, 16'd0);
    rd(v);
    chk("R1/R6 read after reset", v, 16'h0080);

    // R2 R3: enable keeping DONE (bit7=1), first tick at P+1
    cur_req = "R3";
    wr(16'h00C0, 0);
    idle(110);
    chk("R3 irq after 60Hz tick", {15'd0, irq}, 16'd1);
    // R7 R5: write with bit7=0 clears DONE, drops irq
    cur_req = "R7";
    wr(16'h0040, 0);
    chk("R7 irq dropped by DONE clear", {15'd0, irq}, 16'd0);
    rd(v);
    chk("R5 DONE cleared by zero write", v, 16'h0040);
    // R4 odd byte write ignored
    cur_req = "R4";
    wr(16'h0000, 1);
    rd(v);
    chk("R4 odd write ignored", v, 16'h0040);
    // R2 rate change to 50 Hz
    cur_req = "R2";
    load_rate(1);
    idle(400);
    ack();
    load_rate(0);
    idle(250);
    // R8 irq held until ack
    cur_req = "R8";
    chk("R8 irq held", {15'd0, irq}, 16'd1);
    ack();
    chk("R8 irq dropped by ack", {15'd0, irq}, 16'd0);

    // R9 ack clears DONE, monitor hidden (R6)
    cur_req = "R9";
    do_reset(0, 0, 0, 1);
    rd(v);
    chk("R6 DONE hidden on read", v, 16'h0000);
    wr(16'h0040, 0);
    idle(105);
    ack();
    cur_req = "R5";
    wr(16'h0040, 0);
    idle(120);

    // R10 absent register, forced enable
    cur_req = "R10";
    do_reset(1, 1, 1, 0);
    rd(v);
    chk("R10 rdata zero when absent", v, 16'h0000);
    chk("R10 nxm after read", {15'd0, bus_nxm}, 16'd1);
    wr(16'h0040, 0);
    chk("R10 nxm after write", {15'd0, bus_nxm}, 16'd1);
    idle(110);
    chk("R10 forced irq", {15'd0, irq}, 16'd1);
    ack();
    do_reset(1, 0, 1, 0);
    idle(220);
    chk("R10 no irq without force", {15'd0, irq}, 16'd0);

    // R11 ordering: pseudo-random traffic across straps
    cur_req = "R11";
    for (int s = 0; s < 16; s++) begin
      do_reset(s[3], s[2], s[1], s[0]);
      for (int c = 0; c < 900; c++) begin
        @(negedge clk);
        bus_wr    = ($urandom % 9) == 0;
        bus_rd    = ($urandom % 5) == 0;
        bus_odd   = ($urandom % 4) == 0;
        bus_wdata = 16'($urandom);
        iak       = ($urandom % 13) == 0;
        rate_ld   = ($urandom % 300) == 0;
        rate_ld_50 = 1'($urandom);
      end
      @(negedge clk);
      bus_wr = 0; bus_rd = 0; iak = 0; rate_ld = 0; bus_odd = 0;
    end
    idle(2);
    finish_run();
  end
endmodule